// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a 16-bit virtual byte address into a 22-bit physical address. It holds two banks of eight page slots: one for the kernel and one for the user. Each slot pairs a base register with a descriptor register. The 2-bit privilege mode of the access picks the bank, and the top three bits of the virtual address pick the slot. The physical address is the slot base plus the 7-bit block number, shifted left by six, with the 6-bit byte offset in the low bits. Translation is purely combinational. All state is written and read through a small word-wide register port.

Each descriptor holds three things: an access code, a length limit counted in 64-byte blocks, and a growth direction (upward or downward). The block checks every access against the descriptor and raises an abort when the access is not allowed. A status register holds the translation-enable bit. On the first abort it also records the failing slot, the mode and the kind of fault, and a companion register keeps the failing virtual address. That record stays frozen until software clears the fault flags. A descriptor reports whether its page has been written since software last touched that slot.

Top module: `pgx_top`

## Requirements
- R1: While the enable bit (status bit 0) is 0, `pa` equals `acc_va` with six zero bits above it, and `abort` stays 0.
- R2: While enabled and with no abort, `pa` = ((base + va[12:6]) mod 2^16) * 64 + va[5:0], where the base comes from slot va[15:13].
- R3: Mode 0 selects the kernel bank and mode 3 selects the user bank. Modes 1 and 2 abort as nonresident.
- R4: The access code is descriptor bits 2:1. Codes 00 and 10 abort any access as nonresident. Code 01 aborts only writes, as read-only. Code 11 allows both reads and writes.
- R5: Descriptor bit 3 = 0 means the page grows upward. A block number above the length field (descriptor bits 14:8) aborts as a length fault.
- R6: Descriptor bit 3 = 1 means the page grows downward. A block number below the length field aborts as a length fault.
- R7: Descriptor bit 6 reads 1 after a write access to that slot completes without abort. A register write to either the base or the descriptor of that slot clears it.
- R8: Register port addresses work as follows. Address bit 4 picks the bank (0 = kernel, 1 = user), bit 3 picks base (0) or descriptor (1), and bits 2:0 pick the slot. Address 32 is the status register and address 33 is the captured address, which is read-only. Descriptor bits 15, 7, 5, 4 and 0 read 0.
- R9: On an abort while no fault flag is set, the status register records the fault flags in bit 15 (nonresident), bit 14 (length) and bit 13 (read-only), the slot in bits 3:1 and the mode in bits 6:5. Address 33 latches the virtual address. A nonresident fault sets only bit 15. Length and read-only can set together.
- R10: While any of status bits 15:13 is set, later aborts change neither the status register nor the captured address. A software write to the status register takes priority and can clear the record.
- R11: `abort` is 0 whenever `acc_valid` is 0, and no state changes on such a cycle.
- R12: After reset every register reads 0, so translation is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_va | input | 16 | Virtual byte address |
| acc_wr | input | 1 | 1 = write access, 0 = read |
| acc_mode | input | 2 | Privilege mode of the access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register index (see R8) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| pa | output | 22 | Physical address |
| abort | output | 1 | Access refused |

## Verification
Several rules are checked by the assertions on every cycle:
- the pass-through when disabled,
- the abort for illegal modes,
- the silence of `abort` without a request,
- the freeze of the fault record and its first capture,
- the zero reserved bits of a descriptor,
- the matching byte offset of a translated address.

Other behaviour can only be shown by the bench's scenarios against its own model of the register file:
- the exact mapping arithmetic, including the 16-bit wrap of base plus block;
- the upward and downward length limits at their boundary blocks;
- each access code;
- the combined length and read-only flags;
- the set and clear order of the written flag.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int VA_W   = 16;
  localparam int PA_W   = 22;
  localparam int OFF_W  = 6;
  localparam int BN_W   = 7;
  localparam int PG_W   = 3;
  localparam int NPG    = 1 << PG_W;
  localparam int NSET   = 2;
  localparam int RW_W   = 16;
  localparam int RA_W   = 6;
  localparam int BASE_W = PA_W - OFF_W;

  localparam logic [RA_W-1:0] ADDR_SR0 = RA_W'(32);
  localparam logic [RA_W-1:0] ADDR_VAC = RA_W'(33);
  localparam logic [RW_W-1:0] PDR_WMASK = 16'h7F0E;
  localparam logic [RW_W-1:0] SR0_WMASK = 16'hE06F;
  localparam int WFLAG_BIT = 6;

  typedef enum logic [1:0] {
    ACF_NONRES = 2'b00,
    ACF_RDONLY = 2'b01,
    ACF_NEVER  = 2'b10,
    ACF_RDWR   = 2'b11
  } acf_e;

  typedef struct packed {
    logic nonres;
    logic len;
    logic ro;
  } fault_t;

  function automatic logic mode_legal(logic [1:0] mode);
    return (mode == 2'd0) || (mode == 2'd3);
  endfunction

  function automatic logic [PA_W-1:0] map_pa(logic [RW_W-1:0] base,
                                             logic [BN_W-1:0] bn,
                                             logic [OFF_W-1:0] off);
    logic [BASE_W-1:0] blk;
    blk = BASE_W'(base + RW_W'(bn));
    return {blk, off};
  endfunction

  function automatic fault_t judge(logic [RW_W-1:0] pdr, logic [BN_W-1:0] bn,
                                   logic wr, logic mode_ok);
    fault_t f;
    acf_e   acf;
    logic [BN_W-1:0] lim;
    f   = '0;
    acf = acf_e'(pdr[2:1]);
    lim = pdr[14:8];
    if (!mode_ok || acf == ACF_NONRES || acf == ACF_NEVER) begin
      f.nonres = 1'b1;
    end else begin
      f.ro  = (acf == ACF_RDONLY) && wr;
      f.len = pdr[3] ? (bn < lim) : (bn > lim);
    end
    return f;
  endfunction
endpackage

// File: rtl/pgx_pagefile.sv
module pgx_pagefile
  import pgx_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               reg_we,
  input  logic [RA_W-1:0]                    reg_addr,
  input  logic [RW_W-1:0]                    reg_wdata,
  input  logic                               mark_en,
  input  logic                               mark_set,
  input  logic [PG_W-1:0]                    mark_page,
  output logic [NSET-1:0][NPG-1:0][RW_W-1:0] par_v,
  output logic [NSET-1:0][NPG-1:0][RW_W-1:0] pdr_v
);
  for (genvar s = 0; s < NSET; s++) begin : g_set
    for (genvar p = 0; p < NPG; p++) begin : g_pg
      localparam logic [RA_W-1:0] A_PAR = RA_W'(s * 2 * NPG + p);
      localparam logic [RA_W-1:0] A_PDR = RA_W'(s * 2 * NPG + NPG + p);
      logic [RW_W-1:0] par_q, pdr_q;
      logic            wflag_q;
      logic            hit_par, hit_pdr, hit_mark;

      assign hit_par  = reg_we && (reg_addr == A_PAR);
      assign hit_pdr  = reg_we && (reg_addr == A_PDR);
      assign hit_mark = mark_en && (mark_set == s[0]) && (mark_page == PG_W'(p));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          par_q   <= '0;
          pdr_q   <= '0;
          wflag_q <= 1'b0;
        end else begin
          if (hit_par) par_q <= reg_wdata;
          if (hit_pdr) pdr_q <= reg_wdata & PDR_WMASK;
          if (hit_par || hit_pdr) wflag_q <= 1'b0;
          else if (hit_mark)      wflag_q <= 1'b1;
        end
      end

      always_comb begin
        par_v[s][p] = par_q;
        pdr_v[s][p] = pdr_q;
        pdr_v[s][p][WFLAG_BIT] = wflag_q;
      end
    end
  end
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
  import pgx_pkg::*;
(
  input  logic                               en,
  input  logic [VA_W-1:0]                    va,
  input  logic                               wr,
  input  logic [1:0]                         mode,
  input  logic [NSET-1:0][NPG-1:0][RW_W-1:0] par_v,
  input  logic [NSET-1:0][NPG-1:0][RW_W-1:0] pdr_v,
  output logic [PA_W-1:0]                    pa,
  output fault_t                             fault,
  output logic                               mode_ok
);
  logic            set_sel;
  logic [PG_W-1:0] page;
  logic [BN_W-1:0] bn;
  logic [OFF_W-1:0] off;
  logic [RW_W-1:0] base, desc;

  assign set_sel = mode[0];
  assign page    = va[VA_W-1 -: PG_W];
  assign bn      = va[OFF_W +: BN_W];
  assign off     = va[OFF_W-1:0];
  assign base    = par_v[set_sel][page];
  assign desc    = pdr_v[set_sel][page];
  assign mode_ok = mode_legal(mode);

  always_comb begin
    if (en) begin
      pa    = map_pa(base, bn, off);
      fault = judge(desc, bn, wr, mode_ok);
    end else begin
      pa    = PA_W'(va);
      fault = '0;
    end
  end
endmodule

// File: rtl/pgx_status.sv
module pgx_status
  import pgx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sr_we,
  input  logic [RW_W-1:0] wdata,
  input  logic            cap_en,
  input  fault_t          fault,
  input  logic [PG_W-1:0] page,
  input  logic [1:0]      mode,
  input  logic [VA_W-1:0] va,
  output logic [RW_W-1:0] sr0_o,
  output logic [VA_W-1:0] vacap_o,
  output logic            frozen_o,
  output logic            en_o
);
  logic [RW_W-1:0] sr0_q;
  logic [VA_W-1:0] vac_q;

  assign frozen_o = |sr0_q[15:13];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr0_q <= '0;
      vac_q <= '0;
    end else if (sr_we) begin
      sr0_q <= wdata & SR0_WMASK;
    end else if (cap_en && !frozen_o) begin
      sr0_q[15]  <= fault.nonres;
      sr0_q[14]  <= fault.len;
      sr0_q[13]  <= fault.ro;
      sr0_q[6:5] <= mode;
      sr0_q[3:1] <= page;
      vac_q      <= va;
    end
  end

  assign sr0_o   = sr0_q;
  assign vacap_o = vac_q;
  assign en_o    = sr0_q[0];
endmodule

// File: rtl/pgx_top.sv
module pgx_top
  import pgx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic [15:0]     acc_va,
  input  logic            acc_wr,
  input  logic [1:0]      acc_mode,
  input  logic            reg_we,
  input  logic [5:0]      reg_addr,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata,
  output logic [21:0]     pa,
  output logic            abort
);
  logic [NSET-1:0][NPG-1:0][RW_W-1:0] par_v, pdr_v;
  fault_t          xl_fault;
  logic            xl_en, xl_mode_ok, xl_any;
  logic            cap_fire, mark_fire, sr_we_w, sr_frozen;
  logic [RW_W-1:0] sr0_w;
  logic [VA_W-1:0] vacap_w;

  assign xl_any    = |xl_fault;
  assign abort     = acc_valid && xl_any;
  assign cap_fire  = abort;
  assign mark_fire = acc_valid && xl_en && acc_wr && !xl_any && xl_mode_ok;
  assign sr_we_w   = reg_we && (reg_addr == ADDR_SR0);

  pgx_pagefile u_pages (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata,
    .mark_en(mark_fire), .mark_set(acc_mode[0]),
    .mark_page(acc_va[VA_W-1 -: PG_W]),
    .par_v, .pdr_v
  );

  pgx_xlate u_xlate (
    .en(xl_en), .va(acc_va), .wr(acc_wr), .mode(acc_mode),
    .par_v, .pdr_v, .pa, .fault(xl_fault), .mode_ok(xl_mode_ok)
  );

  pgx_status u_status (
    .clk, .rst_n, .sr_we(sr_we_w), .wdata(reg_wdata),
    .cap_en(cap_fire), .fault(xl_fault),
    .page(acc_va[VA_W-1 -: PG_W]), .mode(acc_mode), .va(acc_va),
    .sr0_o(sr0_w), .vacap_o(vacap_w), .frozen_o(sr_frozen), .en_o(xl_en)
  );

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr[5])
      reg_rdata = reg_addr[3] ? pdr_v[reg_addr[4]][reg_addr[2:0]]
                              : par_v[reg_addr[4]][reg_addr[2:0]];
    else if (reg_addr == ADDR_SR0)
      reg_rdata = sr0_w;
    else if (reg_addr == ADDR_VAC)
      reg_rdata = vacap_w;
  end
endmodule

// File: rtl/pgx_sva.sv
module pgx_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [15:0] acc_va,
  input logic [1:0]  acc_mode,
  input logic [21:0] pa,
  input logic        abort,
  input logic        xl_en,
  input logic        sr_frozen,
  input logic        cap_fire,
  input logic        sr_we_w,
  input logic [15:0] sr0_w,
  input logic [15:0] vacap_w,
  input logic [5:0]  reg_addr,
  input logic [15:0] reg_rdata
);
  AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_en |-> (pa == {6'b0, acc_va} && !abort)); // R1
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_en && acc_valid && !abort) |-> (pa[5:0] == acc_va[5:0])); // R2
  AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && xl_en && (acc_mode == 2'd1 || acc_mode == 2'd2)) |-> abort); // R3
  AST_DESC_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_addr[5] && reg_addr[3]) |-> ((reg_rdata & 16'h80B1) == 16'h0)); // R8
  AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && !sr_frozen && !sr_we_w) |=> sr_frozen); // R9
  AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_frozen && !sr_we_w) |=> ($stable(sr0_w) && $stable(vacap_w))); // R10
  AST_NO_REQ_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !abort); // R11
endmodule

bind pgx_top pgx_sva u_sva (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_va(acc_va),
  .acc_mode(acc_mode), .pa(pa), .abort(abort), .xl_en(xl_en),
  .sr_frozen(sr_frozen), .cap_fire(cap_fire), .sr_we_w(sr_we_w),
  .sr0_w(sr0_w), .vacap_w(vacap_w), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/pgx_top_tb.sv
module pgx_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_wr = 1'b0, reg_we = 1'b0;
  logic [15:0] acc_va = '0, reg_wdata = '0;
  logic [1:0]  acc_mode = '0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_rdata;
  logic [21:0] pa;
  logic        abort;

  pgx_top u_dut (.*);

  always #4 clk = ~clk;

  typedef struct {
    logic [22:0] exp;
    logic [22:0] mask;
    bit          is_read;
    string       tag;
  } item_t;
  item_t q[$];

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] m_par [2][8];
  logic [15:0] m_pdr [2][8];
  bit          m_w   [2][8];
  logic [15:0] m_sr0, m_vac;

  function automatic logic [15:0] model_read(logic [5:0] a);
    if (a < 6'd32) begin
      if (a[3]) return m_pdr[a[4]][a[2:0]] | (m_w[a[4]][a[2:0]] ? 16'h0040 : 16'h0);
      return m_par[a[4]][a[2:0]];
    end
    if (a == 6'd32) return m_sr0;
    if (a == 6'd33) return m_vac;
    return 16'h0;
  endfunction

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0; acc_wr = 1'b0; reg_we = 1'b0;
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b0; acc_wr = 1'b0;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    if (a < 6'd32) begin
      if (a[3]) m_pdr[a[4]][a[2:0]] = d & 16'h7F0E;
      else      m_par[a[4]][a[2:0]] = d;
      m_w[a[4]][a[2:0]] = 1'b0;
    end else if (a == 6'd32) begin
      m_sr0 = d & 16'hE06F;
    end
  endtask

  task automatic rd_reg(input logic [5:0] a, input string tag);
    item_t it;
    @(negedge clk);
    acc_valid = 1'b0; acc_wr = 1'b0; reg_we = 1'b0; reg_addr = a;
    it.exp = {7'b0, model_read(a)}; it.mask = 23'h00FFFF;
    it.is_read = 1'b1; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic access(input logic [15:0] va, input bit w, input logic [1:0] md,
                        input bit vld, input string tag);
    item_t it;
    bit en, nr, ln, ro, ab, legal, s;
    logic [15:0] d;
    int blk, plf, base;
    @(negedge clk);
    reg_we = 1'b0;
    acc_valid = vld; acc_va = va; acc_wr = w; acc_mode = md;
    en = m_sr0[0];
    legal = (md == 2'd0) || (md == 2'd3);
    s = (md == 2'd3);
    d = m_pdr[s][va[15:13]];
    blk = int'(va[12:6]); plf = int'(d[14:8]);
    base = int'(m_par[s][va[15:13]]);
    nr = !legal || !d[1];
    ln = !nr && (d[3] ? (blk < plf) : (blk > plf));
    ro = !nr && (d[2:1] == 2'b01) && w;
    if (!en) begin nr = 0; ln = 0; ro = 0; end
    ab = vld && (nr || ln || ro);
    if (!en)
      it.exp = {1'b0, 6'b0, va};
    else
      it.exp = {ab, 22'(((base + blk) % 65536) * 64 + int'(va[5:0]))};
    it.mask = ab ? 23'h400000 : 23'h7FFFFF;
    it.is_read = 1'b0; it.tag = tag;
    q.push_back(it);
    if (ab && m_sr0[15:13] == 3'b000) begin
      m_sr0[15] = nr; m_sr0[14] = ln; m_sr0[13] = ro;
      m_sr0[6:5] = md; m_sr0[3:1] = va[15:13]; m_vac = va;
    end
    if (vld && en && w && !ab && legal) m_w[s][va[15:13]] = 1'b1;
  endtask

  initial begin : monitor
    item_t it;
    logic [22:0] got;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        got = it.is_read ? {7'b0, reg_rdata} : {abort, pa};
        checks++;
        if (((got ^ it.exp) & it.mask) != 0) begin
          errors++;
          $display("FAIL %s actual %h expected %h", it.tag, got & it.mask, it.exp & it.mask);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : script
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 8; p++) begin m_par[s][p] = 0; m_pdr[s][p] = 0; m_w[s][p] = 0; end
    m_sr0 = 0; m_vac = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_reg(6'd32, "R12 status after reset");
    rd_reg(6'd8,  "R12 descriptor after reset");
    access(16'hABCD, 1'b1, 2'd0, 1'b1, "R1 disabled pass-through");
    // program kernel and user slots
    wr_reg(6'd0,  16'h0100); wr_reg(6'd8,  16'h7F06);   // k0 rw up len127
    wr_reg(6'd21, 16'hFFF0); wr_reg(6'd29, 16'h7F06);   // u5 rw, wrapping base
    wr_reg(6'd16, 16'h0200); wr_reg(6'd24, 16'h7F06);   // u0 rw
    wr_reg(6'd9,  16'h7F00);                            // k1 acf 00
    wr_reg(6'd10, 16'h7F02);                            // k2 read-only
    wr_reg(6'd11, 16'h7F04);                            // k3 acf 10
    wr_reg(6'd12, 16'h0A06);                            // k4 up len 10
    wr_reg(6'd14, 16'h780E);                            // k6 down len 120
    wr_reg(6'd32, 16'h0001);
    access(16'h0123, 1'b0, 2'd0, 1'b1, "R2 kernel map");
    access(16'hBFFF, 1'b0, 2'd3, 1'b1, "R2 base+block wrap");
    access(16'h0123, 1'b0, 2'd3, 1'b1, "R3 user bank");
    access(16'h4040, 1'b0, 2'd1, 1'b1, "R3 mode 1 aborts");
    rd_reg(6'd32, "R9 status after mode-1 abort");
    rd_reg(6'd33, "R9 captured address");
    access(16'h6000, 1'b1, 2'd2, 1'b1, "R3 mode 2 aborts");
    rd_reg(6'd32, "R10 status frozen");
    rd_reg(6'd33, "R10 captured address frozen");
    wr_reg(6'd33, 16'h1234);
    rd_reg(6'd33, "R8 captured address read-only");
    wr_reg(6'd32, 16'h0001);
    access(16'h2000, 1'b0, 2'd0, 1'b1, "R4 code 00 aborts");
    rd_reg(6'd32, "R9 nonresident record");
    wr_reg(6'd32, 16'h0001);
    access(16'h4080, 1'b0, 2'd0, 1'b1, "R4 read-only read ok");
    access(16'h4080, 1'b1, 2'd0, 1'b1, "R4 read-only write aborts");
    rd_reg(6'd32, "R9 read-only record");
    wr_reg(6'd32, 16'h0001);
    access(16'h6000, 1'b0, 2'd0, 1'b1, "R4 code 10 aborts");
    wr_reg(6'd32, 16'h0001);
    access(16'h8280, 1'b0, 2'd0, 1'b1, "R5 upward last block");
    access(16'h82C0, 1'b0, 2'd0, 1'b1, "R5 upward past limit");
    rd_reg(6'd32, "R9 length record");
    wr_reg(6'd32, 16'h0001);
    access(16'hDE00, 1'b0, 2'd0, 1'b1, "R6 downward limit block");
    access(16'hDDC0, 1'b0, 2'd0, 1'b1, "R6 downward below limit");
    wr_reg(6'd32, 16'h0001);
    wr_reg(6'd10, 16'h0002);                            // k2 read-only len 0
    access(16'h4140, 1'b1, 2'd0, 1'b1, "R9 length plus read-only");
    rd_reg(6'd32, "R9 combined flags");
    wr_reg(6'd32, 16'h0001);
    access(16'h2000, 1'b1, 2'd0, 1'b0, "R11 no request no abort");
    rd_reg(6'd32, "R11 status untouched");
    rd_reg(6'd9,  "R11 descriptor untouched");
    access(16'h0010, 1'b1, 2'd0, 1'b1, "R7 write access");
    rd_reg(6'd8,  "R7 written flag set");
    rd_reg(6'd24, "R7 other bank flag clear");
    wr_reg(6'd0,  16'h0100);
    rd_reg(6'd8,  "R7 flag cleared by base write");
    access(16'h0010, 1'b1, 2'd0, 1'b1, "R7 write access again");
    wr_reg(6'd8,  16'h7F06);
    rd_reg(6'd8,  "R7 flag cleared by descriptor write");
    wr_reg(6'd31, 16'hFFFF);
    rd_reg(6'd31, "R8 reserved descriptor bits");
    wr_reg(6'd32, 16'h0000);
    access(16'h4140, 1'b1, 2'd0, 1'b1, "R1 disabled again");
    idle(); idle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule